// File: doc/BRIEF.md
# Segment Limit Lookup Checker

This block does the legality test and the limit arithmetic behind an instruction that reads a segment's limit through a selector. The caller presents the selector and the 8-byte descriptor already fetched for it. In long mode it also presents the second 8 bytes of an extended system descriptor. Alongside these come the current privilege level, the present limits of the global and local descriptor tables, a long-mode flag and the operand size. All of them arrive with a single-cycle request strobe.

One clock later the block raises a one-cycle done pulse. With it come a pass flag, a write enable and the sized limit. The pass flag feeds the zero flag. The write enable goes to the destination register, and it stays low whenever any check fails. Descriptor fetch and the register file sit outside the block.

Control is a two-state machine. ST_IDLE waits for work, and ST_REPORT is the cycle in which a result is shown. It has four transitions:
- ACCEPT goes from ST_IDLE to ST_REPORT on a request.
- WAIT stays in ST_IDLE with no request.
- CHAIN stays in ST_REPORT when a new request arrives in the reporting cycle.
- RETIRE goes from ST_REPORT back to ST_IDLE without one.

Descriptor layout used throughout:
- limit field: bits 15..0 (low part) and 51..48 (high part)
- type nibble: bits 43..40
- code/data flag: bit 44 (1 = code/data, 0 = system)
- privilege: bits 46..45
- granularity: bit 55
- for code (type bit 3 set), type bit 2 marks a conforming segment

Top module: `seg_limit_probe`

## Requirements
- R1: A null selector fails: selector bits 15..2 all zero. A selector with bit 2 (table indicator) set and index 0 is not null.
- R2: The selector index (bits 15..3) times 8, plus the descriptor size minus one, must not exceed the chosen table limit. Bit 2 = 0 chooses the global limit and bit 2 = 1 the local one. The descriptor size is 16 bytes for a system descriptor in long mode and 8 bytes otherwise.
- R3: Privilege passes when the descriptor privilege is numerically at least both the current privilege and the selector's bits 1..0, or when the segment is conforming code (bit 44 = 1, type bits 3 and 2 both 1).
- R4: Every descriptor with bit 44 = 1 (code or data) has a valid type in both modes.
- R5: Outside long mode, system types 1, 2, 3, 9 and B (hex) are valid and all other system types fail.
- R6: In long mode only system types 2, 9 and B are valid. Each also needs bits 44..40 of the extended 8 bytes to be zero; those bits are bits 12..8 of the fourth doubleword.
- R7: On success zf and wr_en are both 1. On failure both are 0 and limit_out is 0.
- R8: With granularity 1 the 32-bit limit is the 20-bit field followed by twelve one bits. With granularity 0 it is the 20-bit field zero-extended.
- R9: Operand size 2'b00 keeps only the low 16 bits of the limit. Any other value keeps all 32 bits. Both are zero-extended to the output width.
- R10: Results and a one-cycle done pulse appear exactly one cycle after req_valid. Back-to-back requests give back-to-back results. Without a request, all outputs are zero in the next cycle; the same holds under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per lookup |
| sel | input | 16 | Selector: index 15..3, table bit 2, requested privilege 1..0 |
| desc_lo | input | 64 | First 8 bytes of the descriptor |
| desc_ext | input | 64 | Second 8 bytes of an extended system descriptor |
| cpl | input | 2 | Current privilege level |
| gdt_limit | input | TBL_W | Global table limit in bytes |
| ldt_limit | input | TBL_W | Local table limit in bytes |
| long_mode | input | 1 | 1 selects the long-mode type table and 16-byte system descriptors |
| opsz | input | 2 | Operand size: 00 = 16, 01 = 32, 10/11 = 64 |
| done | output | 1 | Result valid pulse |
| zf | output | 1 | Pass flag for the zero flag |
| wr_en | output | 1 | Destination write enable |
| limit_out | output | OUT_W | Sized segment limit |

## Verification
A stuck or wrongly advanced state register shows up at once: done either misses the cycle after a strobe or lingers a cycle past it. Either error is visible within one clock. Because the registered flags and limit are cleared in every cycle without a request, stale results stand out in the very next cycle. A wrong verdict from any of the three check paths appears as a mismatch between zf and the expected result in the reporting cycle. A slicing error in the limit path appears as wrong limit_out bits in that same cycle.

// File: rtl/seg_limit_pkg.sv
package seg_limit_pkg;

    localparam int SEL_W  = 16;
    localparam int DESC_W = 64;
    localparam int LIM_W  = 20;

    typedef enum logic [1:0] {
        OPSZ_16   = 2'b00,
        OPSZ_32   = 2'b01,
        OPSZ_64   = 2'b10,
        OPSZ_RSVD = 2'b11
    } opsz_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } probe_state_e;

    typedef struct packed {
        logic [LIM_W-1:0] lim20;
        logic [3:0]       kind;
        logic             code_data;
        logic [1:0]       dpl;
        logic             gran;
    } desc_view_t;

    function automatic desc_view_t view_of(input logic [DESC_W-1:0] d);
        desc_view_t v;
        v.lim20     = {d[51:48], d[15:0]};
        v.kind      = d[43:40];
        v.code_data = d[44];
        v.dpl       = d[46:45];
        v.gran      = d[55];
        return v;
    endfunction

endpackage

// File: rtl/seg_sel_bound.sv
module seg_sel_bound #(
    parameter int TBL_W = 32
) (
    input  logic [13:0]      sel_hi,
    input  logic             wide_desc,
    input  logic [TBL_W-1:0] gdt_limit,
    input  logic [TBL_W-1:0] ldt_limit,
    output logic             sel_ok
);
    localparam int EW = (TBL_W > 17) ? TBL_W + 1 : 18;

    logic [EW-1:0] last_byte;
    logic [EW-1:0] table_lim;
    logic          is_null;

    always_comb begin
        is_null   = (sel_hi == 14'd0);
        last_byte = EW'({sel_hi[13:1], 3'b000}) + (wide_desc ? EW'(15) : EW'(7));
        table_lim = sel_hi[0] ? EW'(ldt_limit) : EW'(gdt_limit);
        sel_ok    = !is_null && (last_byte <= table_lim);
    end
endmodule

// File: rtl/seg_type_gate.sv
module seg_type_gate (
    input  logic [3:0] kind,
    input  logic       code_data,
    input  logic [1:0] dpl,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic       long_mode,
    input  logic [4:0] ext_rsvd,
    output logic       wide_desc,
    output logic       type_ok,
    output logic       priv_ok
);
    logic conforming;

    always_comb begin
        conforming = code_data && kind[3] && kind[2];
        priv_ok    = conforming || ((dpl >= cpl) && (dpl >= rpl));
        wide_desc  = long_mode && !code_data;

        if (code_data) begin
            type_ok = 1'b1;
        end else if (long_mode) begin
            case (kind)
                4'h2, 4'h9, 4'hB: type_ok = (ext_rsvd == 5'd0);
                default:          type_ok = 1'b0;
            endcase
        end else begin
            case (kind)
                4'h1, 4'h2, 4'h3, 4'h9, 4'hB: type_ok = 1'b1;
                default:                      type_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/seg_limit_expand.sv
module seg_limit_expand
    import seg_limit_pkg::*;
#(
    parameter int OUT_W = 64
) (
    input  logic [LIM_W-1:0] lim20,
    input  logic             gran,
    input  logic [1:0]       opsz,
    output logic [OUT_W-1:0] limit
);
    localparam int FULL_W = 32;

    logic [FULL_W-1:0] full;
    logic [FULL_W-1:0] sized;

    always_comb begin
        full  = gran ? {lim20, 12'hFFF} : {12'h000, lim20};
        sized = (opsz == OPSZ_16) ? {16'h0000, full[15:0]} : full;
    end

    generate
        if (OUT_W > FULL_W) begin : g_zext
            assign limit = {{(OUT_W-FULL_W){1'b0}}, sized};
        end else begin : g_trunc
            assign limit = sized[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/seg_limit_probe.sv
module seg_limit_probe
    import seg_limit_pkg::*;
#(
    parameter int TBL_W = 32,
    parameter int OUT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [15:0]      sel,
    input  logic [63:0]      desc_lo,
    input  logic [63:0]      desc_ext,
    input  logic [1:0]       cpl,
    input  logic [TBL_W-1:0] gdt_limit,
    input  logic [TBL_W-1:0] ldt_limit,
    input  logic             long_mode,
    input  logic [1:0]       opsz,
    output logic             done,
    output logic             zf,
    output logic             wr_en,
    output logic [OUT_W-1:0] limit_out
);
    desc_view_t       view;
    logic             wide_desc;
    logic             sel_ok;
    logic             type_ok;
    logic             priv_ok;
    logic             pass;
    logic [OUT_W-1:0] limit_calc;
    probe_state_e     state_q;
    probe_state_e     state_d;
    logic             zf_q;
    logic             wr_q;
    logic [OUT_W-1:0] lim_q;

    // Descriptor bits that play no part in the check (base, present, attributes).
    logic unused_bits;
    assign unused_bits = ^{desc_lo[63:56], desc_lo[54:52], desc_lo[47], desc_lo[39:16],
                           desc_ext[63:45], desc_ext[39:0]};

    assign view = view_of(desc_lo);

    seg_type_gate u_type (
        .kind      (view.kind),
        .code_data (view.code_data),
        .dpl       (view.dpl),
        .cpl       (cpl),
        .rpl       (sel[1:0]),
        .long_mode (long_mode),
        .ext_rsvd  (desc_ext[44:40]),
        .wide_desc (wide_desc),
        .type_ok   (type_ok),
        .priv_ok   (priv_ok)
    );

    seg_sel_bound #(.TBL_W(TBL_W)) u_bound (
        .sel_hi    (sel[15:2]),
        .wide_desc (wide_desc),
        .gdt_limit (gdt_limit),
        .ldt_limit (ldt_limit),
        .sel_ok    (sel_ok)
    );

    seg_limit_expand #(.OUT_W(OUT_W)) u_expand (
        .lim20 (view.lim20),
        .gran  (view.gran),
        .opsz  (opsz),
        .limit (limit_calc)
    );

    assign pass = sel_ok && type_ok && priv_ok;

    // Next-state selection: ACCEPT, WAIT, CHAIN, RETIRE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = req_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            zf_q  <= 1'b0;
            wr_q  <= 1'b0;
            lim_q <= '0;
        end else begin
            zf_q  <= pass;
            wr_q  <= pass;
            lim_q <= pass ? limit_calc : '0;
        end
    end

    assign done      = (state_q == ST_REPORT);
    assign zf        = zf_q;
    assign wr_en     = wr_q;
    assign limit_out = lim_q;
endmodule

// File: rtl/seg_limit_probe_chk.sv
module seg_limit_probe_chk #(
    parameter int OUT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [15:0]      sel,
    input logic [1:0]       opsz,
    input logic             done,
    input logic             zf,
    input logic             wr_en,
    input logic [OUT_W-1:0] limit_out
);
    p_done_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && !zf && !wr_en && limit_out == '0));

    p_null_fails_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel[15:2] == 14'd0) |=> !zf);

    p_flag_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_en == zf));

    p_fail_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !zf) |-> (limit_out == '0));

    p_trunc16_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && opsz == 2'b00) |=> ((limit_out >> 16) == '0));

    p_zext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((limit_out >> 32) == '0));
endmodule

bind seg_limit_probe seg_limit_probe_chk #(.OUT_W(OUT_W)) u_chk (.*);

// File: tb/seg_limit_probe_tb.sv
`timescale 1ns/1ps
module seg_limit_probe_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] sel = '0;
    logic [63:0] desc_lo = '0;
    logic [63:0] desc_ext = '0;
    logic [1:0]  cpl = '0;
    logic [31:0] gdt_limit = 32'hFF;
    logic [31:0] ldt_limit = 32'h7F;
    logic        long_mode = 1'b0;
    logic [1:0]  opsz = 2'b01;
    logic        done, zf, wr_en;
    logic [63:0] limit_out;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_tag = "R10";
    string exp_tag = "R10";
    logic  exp_done = 1'b0, exp_ok = 1'b0;
    logic [63:0] exp_lim = '0;
    bit    armed = 1'b0;

    localparam logic [63:0] EXT_CLEAN = 64'hFFFF_E0FF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    seg_limit_probe u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sel(sel),
        .desc_lo(desc_lo), .desc_ext(desc_ext), .cpl(cpl),
        .gdt_limit(gdt_limit), .ldt_limit(ldt_limit), .long_mode(long_mode),
        .opsz(opsz), .done(done), .zf(zf), .wr_en(wr_en), .limit_out(limit_out)
    );

    function automatic logic [63:0] mkd(input logic [19:0] lim, input logic [3:0] kind,
                                        input bit s, input logic [1:0] dpl, input bit g);
        logic [63:0] d;
        d = 64'h7E50_8000_A5C3_E100;
        d[55] = g; d[51:48] = lim[19:16]; d[46:45] = dpl; d[44] = s;
        d[43:40] = kind; d[15:0] = lim[15:0];
        return d;
    endfunction

    // Behavioural reference: returns {pass, limit}.
    function automatic logic [64:0] model();
        bit ok = 1;
        longint unsigned tbl, last, v;
        int span;
        logic [3:0] k = desc_lo[43:40];
        bit is_cd = desc_lo[44];
        int d = desc_lo[46:45];
        if (sel[15:2] == 0) ok = 0;
        tbl  = sel[2] ? longint'(ldt_limit) : longint'(gdt_limit);
        span = (long_mode && !is_cd) ? 16 : 8;
        last = longint'(sel >> 3) * 8 + span - 1;
        if (last > tbl) ok = 0;
        if (!(is_cd && k[3] && k[2]) && (d < int'(cpl) || d < int'(sel[1:0]))) ok = 0;
        if (!is_cd) begin
            if (long_mode) begin
                if (!(k inside {4'h2, 4'h9, 4'hB}) || desc_ext[44:40] != 0) ok = 0;
            end else if (!(k inside {4'h1, 4'h2, 4'h3, 4'h9, 4'hB})) ok = 0;
        end
        v = longint'({desc_lo[51:48], desc_lo[15:0]});
        if (desc_lo[55]) v = v * 4096 + 4095;
        if (opsz == 2'b00) v = v % 65536;
        return ok ? {1'b1, 64'(v)} : 65'd0;
    endfunction

    always @(posedge clk) begin
        logic [64:0] r;
        r = model();
        cycles <= cycles + 1;
        exp_tag <= cur_tag;
        if (!rst_n || !req_valid) begin
            exp_done <= 1'b0; exp_ok <= 1'b0; exp_lim <= '0;
        end else begin
            exp_done <= 1'b1; exp_ok <= r[64]; exp_lim <= r[63:0];
        end
        armed <= 1'b1;
    end

    always @(negedge clk) begin
        if (armed) begin
            n_checks++;
            if (done !== exp_done || zf !== exp_ok || wr_en !== exp_ok || limit_out !== exp_lim) begin
                n_fail++;
                $display("FAIL %s: got done=%b zf=%b wr=%b lim=%h, expected done=%b zf=%b wr=%b lim=%h",
                         exp_tag, done, zf, wr_en, limit_out, exp_done, exp_ok, exp_ok, exp_lim);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic issue(input string tag, input logic [15:0] s, input logic [63:0] d,
                         input logic [63:0] e, input logic [1:0] c, input bit lm,
                         input logic [1:0] oz);
        @(negedge clk);
        cur_tag = tag; req_valid = 1'b1; sel = s; desc_lo = d; desc_ext = e;
        cpl = c; long_mode = lm; opsz = oz;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur_tag = "R10"; req_valid = 1'b0;
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R1: null selectors and a local-table index 0
        issue("R1", 16'h0000, mkd(20'h00123, 4'h2, 1, 3, 0), EXT_CLEAN, 0, 0, 1);
        issue("R1", 16'h0003, mkd(20'h00123, 4'h2, 1, 3, 0), EXT_CLEAN, 0, 0, 1);
        issue("R1", 16'h0004, mkd(20'h00123, 4'h2, 1, 3, 0), EXT_CLEAN, 0, 0, 1);
        idle(1);
        // R2: table bounds, both tables, 16-byte system descriptors
        issue("R2", 16'h00F8, mkd(20'h00456, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        issue("R2", 16'h0100, mkd(20'h00456, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        issue("R2", 16'h007C, mkd(20'h00456, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        issue("R2", 16'h0084, mkd(20'h00456, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        issue("R2", 16'h00F0, mkd(20'h00456, 4'h9, 0, 0, 0), EXT_CLEAN, 0, 1, 1);
        issue("R2", 16'h00F8, mkd(20'h00456, 4'h9, 0, 0, 0), EXT_CLEAN, 0, 1, 1);
        idle(1);
        // R3: privilege and conforming code
        issue("R3", 16'h0010, mkd(20'h00777, 4'h2, 1, 0, 0), EXT_CLEAN, 3, 0, 1);
        issue("R3", 16'h0010, mkd(20'h00777, 4'hE, 1, 0, 0), EXT_CLEAN, 3, 0, 1);
        issue("R3", 16'h0010, mkd(20'h00777, 4'hA, 1, 0, 0), EXT_CLEAN, 3, 0, 1);
        issue("R3", 16'h0013, mkd(20'h00777, 4'h2, 1, 2, 0), EXT_CLEAN, 0, 0, 1);
        issue("R3", 16'h0013, mkd(20'h00777, 4'h2, 1, 3, 0), EXT_CLEAN, 2, 0, 1);
        issue("R3", 16'h0012, mkd(20'h00777, 4'h2, 1, 2, 0), EXT_CLEAN, 1, 0, 1);
        // R4: every code/data type in both modes
        for (int k = 0; k < 16; k++) begin
            issue("R4", 16'h0020, mkd(20'h01000 + 20'(k), 4'(k), 1, 0, 0), EXT_CLEAN, 0, 0, 1);
            issue("R4", 16'h0020, mkd(20'h02000 + 20'(k), 4'(k), 1, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 1);
        end
        idle(1);
        // R5: legacy system types
        for (int k = 0; k < 16; k++)
            issue("R5", 16'h0030, mkd(20'h03000 + 20'(k), 4'(k), 0, 0, 0), EXT_CLEAN, 0, 0, 1);
        idle(1);
        // R6: long-mode system types and the reserved extended bits
        for (int k = 0; k < 16; k++)
            issue("R6", 16'h0030, mkd(20'h04000 + 20'(k), 4'(k), 0, 0, 0), EXT_CLEAN, 0, 1, 2);
        for (int b = 40; b < 45; b++) begin
            logic [63:0] e = EXT_CLEAN;
            e[b] = 1'b1;
            issue("R6", 16'h0030, mkd(20'h05555, 4'hB, 0, 0, 0), e, 0, 1, 2);
        end
        issue("R6", 16'h0030, mkd(20'h05555, 4'h2, 0, 0, 0), 64'h0000_0000_0000_0000, 0, 1, 2);
        idle(1);
        // R7: failure leaves limit zero
        issue("R7", 16'h0030, mkd(20'hFFFFF, 4'h0, 0, 3, 1), EXT_CLEAN, 0, 0, 2);
        // R8: granularity
        issue("R8", 16'h0040, mkd(20'hABCDE, 4'h3, 1, 0, 1), EXT_CLEAN, 0, 0, 1);
        issue("R8", 16'h0040, mkd(20'hFFFFF, 4'h3, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        issue("R8", 16'h0040, mkd(20'h00000, 4'h3, 1, 0, 1), EXT_CLEAN, 0, 0, 1);
        // R9: operand sizes
        for (int o = 0; o < 4; o++) begin
            issue("R9", 16'h0048, mkd(20'h9A5B3, 4'h2, 1, 0, 1), EXT_CLEAN, 0, 1, 2'(o));
            issue("R9", 16'h0048, mkd(20'h9A5B3, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 2'(o));
        end
        // R10: gaps and a mid-stream reset
        idle(3);
        issue("R10", 16'h0050, mkd(20'h12345, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        idle(1);
        issue("R10", 16'h0050, mkd(20'h12345, 4'h2, 1, 0, 0), EXT_CLEAN, 0, 0, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; req_valid = 1'b0;
        idle(3);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule